// File: doc/BRIEF.md
# Register Slave with Coded Failure Responses

This block is a small memory-mapped register slave that sits behind a one-request-per-cycle port. Each request carries a valid strobe, a read/write flag, an address and 64 bits of write data. Every read is answered exactly one cycle later with 64 bits of read data. The block holds two registers. The first is a read-only build-identification word, fixed when the design is elaborated. The second is a reset-control register that drives active-low reset lines to up to four attached devices.

When an access cannot be served, a read does not return a plain bus error. It returns a 32-bit diagnostic word, zero-extended to 64 bits, and the word tells software why the access failed:

- the address is misaligned;
- the address lies outside every decoded range;
- the address is inside the register group but at an offset that holds no register;
- the address is inside a defined range that nothing services.

A write that cannot be served changes no state and raises a one-cycle error pulse.

The address is split into three fields, from the top down: the upper bits, a group index and a byte offset. The upper bits must be zero. Group 0 holds the registers. Groups 1 up to `NUM_GROUPS-1` are defined but not serviced. Any higher group index, or any non-zero upper bit, is out of range.

Top module: `diag_reg_slave`

## Requirements
- R1: A read of group 0, offset 0 returns, one cycle later, the identification word zero-extended to 64 bits. Its bits [31:29] hold `RATE_CODE`, bit 28 holds `DIRTY` and bits [27:0] hold `BUILD_ID`.
- R2: A write to the identification word changes nothing that a later read returns, and raises no error pulse.
- R3: After reset, the reset-control register at group 0, offset 4 reads 0x3F, and all `dev_rst_n` lines are 1.
- R4: A write to offset 4 stores write-data bits [5:0], which take effect in the cycle after the request. `dev_rst_n[i]` follows stored bit i+2, so writing 0x37 clears bit 3 and holds device 1 in reset until that bit is written to 1 again.
- R5: A read whose address has bits [1:0] not equal to zero returns 0xDEC0DEFF. This check takes precedence over every other classification, including out-of-range.
- R6: An aligned read with any upper address bit set, or with a group index of `NUM_GROUPS` or more, returns 0xDEC0DE1C.
- R7: An aligned read in group 0 at an offset other than 0 or 4 returns 0xDEC0DE00.
- R8: An aligned read in groups 1 to `NUM_GROUPS-1` returns 0xDEC0DE0B.
- R9: A write to a misaligned, out-of-range, unpopulated or unserviced address leaves all register state unchanged. It raises `wr_err` for exactly the cycle after the request. A write to offset 0 or 4 never raises `wr_err`.
- R10: `rsp_valid` is high in the cycle after a read request and only then. Bits [63:32] of `rsp_rdata` are always zero while `rsp_valid` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 64 | Write data; bits [5:0] are used by the reset-control register |
| rsp_valid | output | 1 | Read data is valid |
| rsp_rdata | output | 64 | Read data or zero-extended diagnostic word |
| wr_err | output | 1 | One-cycle pulse for a rejected write |
| dev_rst_n | output | NUM_DEV | Active-low reset to each attached device |

## Verification
The bench builds the slave with `NUM_GROUPS` set to 3. This gives two unserviced groups, at 0x100 and 0x200, an out-of-range group index at 0x300, and out-of-range upper bits from 0x400 upward, so every diagnostic class appears at more than one address. The identification parameters are set to non-zero values with the dirty flag high, so a field placed in the wrong bits shows up in the read data. Misaligned addresses inside the out-of-range and unserviced windows exercise the precedence of the alignment check. A long run of mixed reads and writes then compares every cycle against a behavioural model.

// File: rtl/diag_reg_pkg.sv
package diag_reg_pkg;

    typedef enum logic [2:0] {
        ACC_VERSION   = 3'd0,
        ACC_CTRL      = 3'd1,
        ACC_MISALIGN  = 3'd2,
        ACC_OUTRANGE  = 3'd3,
        ACC_UNPOP     = 3'd4,
        ACC_UNHANDLED = 3'd5
    } acc_kind_e;

    localparam logic [31:0] CODE_MISALIGN  = 32'hDEC0_DEFF;
    localparam logic [31:0] CODE_OUTRANGE  = 32'hDEC0_DE1C;
    localparam logic [31:0] CODE_UNPOP     = 32'hDEC0_DE00;
    localparam logic [31:0] CODE_UNHANDLED = 32'hDEC0_DE0B;

    // Diagnostic word for a failed access class; zero for served classes.
    function automatic logic [31:0] diag_word(acc_kind_e k);
        logic [31:0] w;
        case (k)
            ACC_MISALIGN:  w = CODE_MISALIGN;
            ACC_OUTRANGE:  w = CODE_OUTRANGE;
            ACC_UNPOP:     w = CODE_UNPOP;
            ACC_UNHANDLED: w = CODE_UNHANDLED;
            default:       w = 32'h0;
        endcase
        return w;
    endfunction

    function automatic logic is_served(acc_kind_e k);
        return (k == ACC_VERSION) || (k == ACC_CTRL);
    endfunction

endpackage

// File: rtl/diag_addr_classify.sv
// Sorts one address into a served register or a failure class.
// Order of tests: alignment, range, register existence, handler.
module diag_addr_classify
    import diag_reg_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int OFF_W      = 8,
    parameter int GRP_W      = 2,
    parameter int NUM_GROUPS = 2,
    parameter int VER_OFF    = 0,
    parameter int CTRL_OFF   = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output acc_kind_e         kind
);

    localparam int TOP_LSB = OFF_W + GRP_W;
    localparam logic [GRP_W:0] NG_L = (GRP_W + 1)'(NUM_GROUPS);

    logic             upper_hit;
    logic [GRP_W-1:0] grp;
    logic [OFF_W-1:0] off;
    logic             misaligned;
    logic             grp_known;

    generate
        if (ADDR_W > TOP_LSB) begin : g_upper
            assign upper_hit = |addr[ADDR_W-1:TOP_LSB];
        end else begin : g_no_upper
            assign upper_hit = 1'b0;
        end
    endgenerate

    assign grp        = addr[TOP_LSB-1:OFF_W];
    assign off        = addr[OFF_W-1:0];
    assign misaligned = |addr[1:0];
    assign grp_known  = ({1'b0, grp} < NG_L);

    always_comb begin
        if (misaligned) begin
            kind = ACC_MISALIGN;
        end else if (upper_hit || !grp_known) begin
            kind = ACC_OUTRANGE;
        end else if (grp == '0) begin
            if (off == OFF_W'(VER_OFF)) begin
                kind = ACC_VERSION;
            end else if (off == OFF_W'(CTRL_OFF)) begin
                kind = ACC_CTRL;
            end else begin
                kind = ACC_UNPOP;
            end
        end else begin
            kind = ACC_UNHANDLED;
        end
    end

endmodule

// File: rtl/diag_ctrl_reg.sv
// Writable reset-control storage with a parameterised reset value.
module diag_ctrl_reg #(
    parameter int              CTRL_W  = 6,
    parameter logic [CTRL_W-1:0] RST_VAL = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [CTRL_W-1:0] wdata,
    output logic [CTRL_W-1:0] q
);

    logic [CTRL_W-1:0] ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (we) begin
            ctrl_d = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= RST_VAL;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign q = ctrl_q;

endmodule

// File: rtl/diag_reg_slave.sv
module diag_reg_slave
    import diag_reg_pkg::*;
#(
    parameter int              ADDR_W     = 16,
    parameter int              OFF_W      = 8,
    parameter int              GRP_W      = 2,
    parameter int              NUM_GROUPS = 2,
    parameter int              NUM_DEV    = 4,
    parameter int              CTRL_W     = 6,
    parameter int              DEV_LSB    = 2,
    parameter logic [CTRL_W-1:0] CTRL_RST = 6'h3F,
    parameter logic [2:0]      RATE_CODE  = 3'd1,
    parameter logic            DIRTY      = 1'b0,
    parameter logic [27:0]     BUILD_ID   = 28'h0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [63:0]        req_wdata,
    output logic               rsp_valid,
    output logic [63:0]        rsp_rdata,
    output logic               wr_err,
    output logic [NUM_DEV-1:0] dev_rst_n
);

    localparam int          DATA_W   = 64;
    localparam logic [31:0] VER_WORD = {RATE_CODE, DIRTY, BUILD_ID};

    typedef struct packed {
        logic              rsp_valid;
        logic [DATA_W-1:0] rsp_rdata;
        logic              wr_err;
    } slave_st_t;

    slave_st_t         st_d, st_q;
    acc_kind_e         kind;
    logic              ctrl_we;
    logic [CTRL_W-1:0] ctrl_q;
    logic              unused_wdata;

    assign unused_wdata = ^req_wdata[DATA_W-1:CTRL_W];

    diag_addr_classify #(
        .ADDR_W    (ADDR_W),
        .OFF_W     (OFF_W),
        .GRP_W     (GRP_W),
        .NUM_GROUPS(NUM_GROUPS),
        .VER_OFF   (0),
        .CTRL_OFF  (4)
    ) u_classify (
        .addr(req_addr),
        .kind(kind)
    );

    diag_ctrl_reg #(
        .CTRL_W (CTRL_W),
        .RST_VAL(CTRL_RST)
    ) u_ctrl (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (ctrl_we),
        .wdata(req_wdata[CTRL_W-1:0]),
        .q    (ctrl_q)
    );

    assign ctrl_we = req_valid && req_write && (kind == ACC_CTRL);

    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = req_valid && !req_write;
        st_d.wr_err    = req_valid && req_write && !is_served(kind);
        st_d.rsp_rdata = '0;
        if (req_valid && !req_write) begin
            case (kind)
                ACC_VERSION: st_d.rsp_rdata = {{(DATA_W-32){1'b0}}, VER_WORD};
                ACC_CTRL:    st_d.rsp_rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
                default:     st_d.rsp_rdata = {{(DATA_W-32){1'b0}}, diag_word(kind)};
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid = st_q.rsp_valid;
    assign rsp_rdata = st_q.rsp_rdata;
    assign wr_err    = st_q.wr_err;

    generate
        for (genvar i = 0; i < NUM_DEV; i++) begin : g_dev
            assign dev_rst_n[i] = ctrl_q[DEV_LSB + i];
        end
    endgenerate

endmodule

// File: rtl/diag_reg_slave_chk.sv
module diag_reg_slave_chk #(
    parameter int          ADDR_W     = 16,
    parameter int          OFF_W      = 8,
    parameter int          NUM_GROUPS = 2,
    parameter int          NUM_DEV    = 4,
    parameter logic [2:0]  RATE_CODE  = 3'd1,
    parameter logic        DIRTY      = 1'b0,
    parameter logic [27:0] BUILD_ID   = 28'h0
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_write,
    input logic [ADDR_W-1:0]  req_addr,
    input logic               rsp_valid,
    input logic [63:0]        rsp_rdata,
    input logic               wr_err,
    input logic [NUM_DEV-1:0] dev_rst_n
);

    logic rd_req, wr_req, aligned;
    assign rd_req  = req_valid && !req_write;
    assign wr_req  = req_valid && req_write;
    assign aligned = (req_addr[1:0] == 2'b00);

    // R1
    a_r1_version_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && (req_addr == '0) |=> rsp_rdata == {32'h0, RATE_CODE, DIRTY, BUILD_ID});

    // R4 / R2: reset lines move only on a write
    a_r4_dev_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_req |=> $stable(dev_rst_n));

    // R5
    a_r5_misaligned: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && !aligned |=> rsp_rdata == 64'h0000_0000_DEC0_DEFF);

    // R6
    a_r6_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && aligned && (32'(req_addr) >= (32'(NUM_GROUPS) << OFF_W))
        |=> rsp_rdata == 64'h0000_0000_DEC0_DE1C);

    // R9
    a_r9_err_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_req |=> !wr_err);

    // R10
    a_r10_rsp_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> rsp_valid == $past(rd_req));

    a_r10_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_rdata[63:32] == 32'h0);

endmodule

bind diag_reg_slave diag_reg_slave_chk #(
    .ADDR_W    (ADDR_W),
    .OFF_W     (OFF_W),
    .NUM_GROUPS(NUM_GROUPS),
    .NUM_DEV   (NUM_DEV),
    .RATE_CODE (RATE_CODE),
    .DIRTY     (DIRTY),
    .BUILD_ID  (BUILD_ID)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_addr (req_addr),
    .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata),
    .wr_err   (wr_err),
    .dev_rst_n(dev_rst_n)
);

// File: tb/tb_diag_reg_slave.sv
module tb_diag_reg_slave;

    localparam int          AW   = 16;
    localparam int          NG   = 3;
    localparam logic [2:0]  RATE = 3'd3;
    localparam logic        DRTY = 1'b1;
    localparam logic [27:0] BID  = 28'h5A1_B3C4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [63:0]   req_wdata = '0;
    logic          rsp_valid;
    logic [63:0]   rsp_rdata;
    logic          wr_err;
    logic [3:0]    dev_rst_n;

    int checks = 0;
    int errors = 0;
    int ctrl_m = 'h3F;

    always #5 clk = ~clk;

    diag_reg_slave #(
        .ADDR_W    (AW),
        .NUM_GROUPS(NG),
        .RATE_CODE (RATE),
        .DIRTY     (DRTY),
        .BUILD_ID  (BID)
    ) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_write(req_write),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata),
        .wr_err   (wr_err),
        .dev_rst_n(dev_rst_n)
    );

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Behavioural read model.
    function automatic logic [63:0] model_read(int a);
        if (a % 4 != 0)      return 64'hDEC0_DEFF;
        if (a >= NG * 256)   return 64'hDEC0_DE1C;
        if (a >= 256)        return 64'hDEC0_DE0B;
        if (a == 0)          return {32'h0, RATE, DRTY, BID};
        if (a == 4)          return 64'(ctrl_m);
        return 64'hDEC0_DE00;
    endfunction

    task automatic step(bit v, bit w, int a, logic [63:0] d, string req);
        bit          ev, ee;
        logic [63:0] erd;
        ev  = v && !w;
        erd = ev ? model_read(a) : 64'h0;
        ee  = v && w && !(a == 0 || a == 4);
        if (v && w && a == 4) ctrl_m = int'(d[5:0]);
        req_valid = v;
        req_write = w;
        req_addr  = AW'(a);
        req_wdata = d;
        @(negedge clk);
        chk({req, " rsp_valid"}, 64'(rsp_valid), 64'(ev));
        if (ev) chk({req, " rdata"}, rsp_rdata, erd);
        chk({req, " wr_err"}, 64'(wr_err), 64'(ee));
        chk({req, " dev_rst_n"}, 64'(dev_rst_n), 64'((ctrl_m >> 2) & 'hF));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R3: reset state
        chk("R3 reset rsp_valid", 64'(rsp_valid), 64'h0);
        chk("R3 reset wr_err", 64'(wr_err), 64'h0);
        chk("R3 reset dev_rst_n", 64'(dev_rst_n), 64'hF);
        rst_n = 1'b1;
        @(negedge clk);
        step(1, 0, 4, 0, "R3");
        step(1, 0, 0, 0, "R1");
        step(1, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF, "R2");
        step(1, 0, 0, 0, "R2");
        step(1, 1, 4, 64'h37, "R4");
        step(0, 0, 0, 0, "R4");
        step(1, 0, 4, 0, "R4");
        step(1, 1, 4, 64'hFFFF_FF3F, "R4");
        step(1, 1, 4, 64'h03, "R4");
        step(1, 1, 4, 64'h3F, "R4");
        step(1, 0, 1, 0, "R5");
        step(1, 0, 2, 0, "R5");
        step(1, 0, 3, 0, "R5");
        step(1, 0, 'h105, 0, "R5");
        step(1, 0, 'h302, 0, "R5");
        step(1, 0, 'h8001, 0, "R5");
        step(1, 0, 'h300, 0, "R6");
        step(1, 0, 'h400, 0, "R6");
        step(1, 0, 'hFFFC, 0, "R6");
        step(1, 0, 'h8, 0, "R7");
        step(1, 0, 'hFC, 0, "R7");
        step(1, 0, 'h100, 0, "R8");
        step(1, 0, 'h2FC, 0, "R8");
        step(1, 1, 'h5, 64'h0, "R9");
        step(1, 1, 'h300, 64'h0, "R9");
        step(1, 1, 'h8, 64'h0, "R9");
        step(1, 1, 'h104, 64'h0, "R9");
        step(0, 0, 0, 0, "R9");
        step(1, 0, 4, 0, "R9");
        step(0, 1, 4, 64'h0, "R10");
        step(0, 0, 0, 0, "R10");
        for (int i = 0; i < 400; i++) begin
            int a;
            int sel;
            sel = int'($urandom % 4);
            a   = (sel == 0) ? int'(($urandom % 2) * 4) : int'($urandom % 'h500);
            step(bit'($urandom % 4 != 0), bit'($urandom % 2), a,
                 {$urandom, $urandom}, "R10 mixed");
        end
        step(0, 0, 0, 0, "R10");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R10 watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule